// File: doc/BRIEF.md
# Receive Status and Interrupt Controller for a Serial Audio Input

This block is the status side of a serial audio receiver. Upstream decoding logic gives it finished subframe words, a pulse when the initial lock-on phase finishes, a pulse for each block-start preamble, and control words with a valid strobe. The block holds received words in two stages: a hidden holding buffer that feeds a data register visible to software. It checks the parity of every subframe and keeps six status flags. A single interrupt line is driven from those flags through a per-flag enable mask.

Software reaches the block through a small register port. The port provides a data register, a control-word register, a status register, a clear register and an interrupt-enable register. Error and event flags stay set until software writes a one to their bit in the clear register. The two availability flags clear as a side effect of reading the register they describe. When both stages are full and a further word arrives, the word already waiting is kept and the new word is thrown away.

Register addresses: 0 is data (read), 1 is control word (read), 2 is status (read), 3 is clear (write), 4 is interrupt enable (read/write). Status and enable bit positions: bit 0 is data ready, bit 1 is control word available, bit 2 is parity error, bit 3 is overrun, bit 4 is block start seen, bit 5 is sync done. Unused high bits read as zero.

Top module: `rx_status_ctrl`

## Requirements
- R1: After reset all six status bits read 0, the enable register reads 0, `irq` is 0, and both buffer stages are empty.
- R2: A word that arrives while both stages are empty is in the data register one cycle later, and status bit 0 is set. A read of address 0 returns that word, and status bit 0 is 0 after that read.
- R3: A word that arrives while the data register is full waits in the holding buffer. After the data register is read, status bit 0 is 0 for exactly one cycle and is then set again. The next read of address 0 returns the waiting word, so arrival order is kept.
- R4: A word that arrives while both stages are full sets status bit 3 and is dropped. The data register keeps its earlier word, and reads return the two older words in their original order.
- R5: Status bit 2 is set when subframe bits 31 down to 4 of a received word contain an odd number of ones. Bits 3 to 0 do not affect the check.
- R6: A control-valid strobe loads the control word and sets status bit 1. A read of address 1 returns the word and clears bit 1.
- R7: A sync-done pulse sets status bit 5. A block-start pulse sets status bit 4.
- R8: Writing to address 3 clears each of status bits 2 to 5 that has a 1 in the written data. Zero bits have no effect, and bits 0 and 1 are not affected by this write.
- R9: When a set event and a clear write for the same bit fall in the same cycle, the bit ends up set.
- R10: `irq` is 1 exactly when some status bit and its enable bit (address 4, bits 5 to 0, same positions) are both 1. The enable register reads back as written.
- R11: A read of the status register (address 2) changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | A decoded subframe word is present |
| word_in | input | WORD_W | Decoded subframe word |
| sync_pulse | input | 1 | Initial synchronization finished |
| blk_pulse | input | 1 | Block-start preamble detected |
| ctrl_valid | input | 1 | Control word ready |
| ctrl_in | input | CTRL_W | Control word |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data for the current address (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The two-stage path is tested with three stimulus patterns:
- A single word with reads in between, which shows the direct load into the data register.
- Two words back to back, which shows the holding buffer and the one-cycle gap in data ready after a read.
- Three or more words in a row, which shows that overrun drops the newest word and not the older ones.

Parity is tested with three kinds of word: a correct word, a word with one bit flipped inside the checked field, and a word with bits flipped only below bit 4. This separates the checked field from the ignored low bits. The clear register is tested in four ways: all-zero writes, writes to the read-cleared bits, full clears, and clears that collide with a set pulse. These cases separate the two clearing styles and the set-wins rule.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
   localparam int NFLAG   = 6;
   localparam int FL_DRDY = 0;
   localparam int FL_CTRL = 1;
   localparam int FL_PERR = 2;
   localparam int FL_OVR  = 3;
   localparam int FL_BLK  = 4;
   localparam int FL_SYNC = 5;
   // flags cleared by write-one (1) versus by a read side effect (0)
   localparam logic [NFLAG-1:0] W1C_MASK = 6'b111100;

   typedef enum logic [2:0] {
      RA_DATA = 3'd0,
      RA_CTRL = 3'd1,
      RA_STAT = 3'd2,
      RA_CLR  = 3'd3,
      RA_EN   = 3'd4
   } reg_addr_e;
endpackage

// File: rtl/rxs_parity.sv
module rxs_parity #(
   parameter int WORD_W   = 32,
   parameter int PAR_LO   = 4,
   parameter int PAR_IMPL = 0
) (
   input  logic [WORD_W-1:0] word,
   output logic              odd
);
   localparam int SPAN = WORD_W - PAR_LO;

   initial begin
      if (PAR_LO < 0 || PAR_LO >= WORD_W) $error("rxs_parity: PAR_LO out of range");
      if (PAR_IMPL != 0 && PAR_IMPL != 1) $error("rxs_parity: PAR_IMPL must be 0 or 1");
   end

   logic [SPAN-1:0] field;
   assign field = word[WORD_W-1:PAR_LO];

   generate
      if (PAR_IMPL == 0) begin : g_reduce
         assign odd = ^field;
      end else begin : g_chain
         always_comb begin
            odd = 1'b0;
            for (int i = 0; i < SPAN; i++) odd = odd ^ field[i];
         end
      end
   endgenerate
endmodule

// File: rtl/rxs_data_path.sv
module rxs_data_path #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   input  logic              pop,
   output logic [WORD_W-1:0] dr_word,
   output logic              dr_full,
   output logic              hold_full,
   output logic              load_evt,
   output logic              ovr_evt
);
   logic [WORD_W-1:0] hold_word;
   logic move, direct, to_hold, hold_free;

   assign move      = hold_full && !dr_full;
   assign hold_free = !hold_full || move;
   assign direct    = in_valid && !dr_full && !hold_full;
   assign to_hold   = in_valid && !direct && hold_free;
   assign ovr_evt   = in_valid && dr_full && hold_full;
   assign load_evt  = direct || move;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dr_full   <= 1'b0;
         hold_full <= 1'b0;
         dr_word   <= '0;
         hold_word <= '0;
      end else begin
         if (direct) begin
            dr_word <= in_word;
            dr_full <= 1'b1;
         end else if (move) begin
            dr_word <= hold_word;
            dr_full <= 1'b1;
         end else if (pop) begin
            dr_full <= 1'b0;
         end
         if (to_hold) begin
            hold_word <= in_word;
            hold_full <= 1'b1;
         end else if (move) begin
            hold_full <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/rxs_flag_bank.sv
module rxs_flag_bank #(
   parameter int            N    = 6,
   parameter logic [N-1:0]  MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic [N-1:0] wclr_vec,
   input  logic [N-1:0] rclr_vec,
   input  logic [N-1:0] en_vec,
   output logic [N-1:0] flags,
   output logic         irq
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_flag
         logic clr;
         if (MASK[i]) begin : g_w1c
            assign clr = wclr_vec[i];
         end else begin : g_rdc
            assign clr = rclr_vec[i];
         end
         always_ff @(posedge clk) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= set_vec[i] | (flags[i] & ~clr);
         end
      end
   endgenerate

   assign irq = |(flags & en_vec);
endmodule

// File: rtl/rx_status_ctrl.sv
module rx_status_ctrl
   import rxs_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int PAR_LO   = 4,
   parameter int CTRL_W   = 32,
   parameter int ADDR_W   = 3,
   parameter int BUS_W    = 32,
   parameter int PAR_IMPL = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_valid,
   input  logic [WORD_W-1:0] word_in,
   input  logic              sync_pulse,
   input  logic              blk_pulse,
   input  logic              ctrl_valid,
   input  logic [CTRL_W-1:0] ctrl_in,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              irq
);
   initial begin
      if (ADDR_W < 3)      $error("rx_status_ctrl: ADDR_W must be at least 3");
      if (BUS_W < NFLAG)   $error("rx_status_ctrl: BUS_W narrower than flag set");
      if (WORD_W > BUS_W)  $error("rx_status_ctrl: WORD_W wider than bus");
      if (CTRL_W > BUS_W)  $error("rx_status_ctrl: CTRL_W wider than bus");
   end

   logic sel_data, sel_ctrl, sel_stat, sel_clr, sel_en;
   assign sel_data = bus_addr == ADDR_W'(RA_DATA);
   assign sel_ctrl = bus_addr == ADDR_W'(RA_CTRL);
   assign sel_stat = bus_addr == ADDR_W'(RA_STAT);
   assign sel_clr  = bus_addr == ADDR_W'(RA_CLR);
   assign sel_en   = bus_addr == ADDR_W'(RA_EN);

   logic rd_data, rd_ctrl, wr_clr, wr_en;
   assign rd_data = bus_rd && sel_data;
   assign rd_ctrl = bus_rd && sel_ctrl;
   assign wr_clr  = bus_wr && sel_clr;
   assign wr_en   = bus_wr && sel_en;

   logic [WORD_W-1:0] dr_word;
   logic dr_full, hold_full, load_evt, ovr_evt, par_odd;

   rxs_data_path #(.WORD_W(WORD_W)) path_i (
      .clk(clk), .rst_n(rst_n), .in_valid(word_valid), .in_word(word_in),
      .pop(rd_data), .dr_word(dr_word), .dr_full(dr_full),
      .hold_full(hold_full), .load_evt(load_evt), .ovr_evt(ovr_evt)
   );

   rxs_parity #(.WORD_W(WORD_W), .PAR_LO(PAR_LO), .PAR_IMPL(PAR_IMPL)) par_i (
      .word(word_in), .odd(par_odd)
   );

   logic [CTRL_W-1:0] ctrl_q;
   logic [NFLAG-1:0]  en_q, flags_q, set_vec, wclr_vec, rclr_vec;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         en_q   <= '0;
      end else begin
         if (ctrl_valid) ctrl_q <= ctrl_in;
         if (wr_en)      en_q   <= bus_wdata[NFLAG-1:0];
      end
   end

   always_comb begin
      set_vec          = '0;
      set_vec[FL_DRDY] = load_evt;
      set_vec[FL_CTRL] = ctrl_valid;
      set_vec[FL_PERR] = word_valid && par_odd;
      set_vec[FL_OVR]  = ovr_evt;
      set_vec[FL_BLK]  = blk_pulse;
      set_vec[FL_SYNC] = sync_pulse;
      wclr_vec         = wr_clr ? bus_wdata[NFLAG-1:0] : '0;
      rclr_vec          = '0;
      rclr_vec[FL_DRDY] = rd_data;
      rclr_vec[FL_CTRL] = rd_ctrl;
   end

   rxs_flag_bank #(.N(NFLAG), .MASK(W1C_MASK)) flags_i (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .wclr_vec(wclr_vec),
      .rclr_vec(rclr_vec), .en_vec(en_q), .flags(flags_q), .irq(irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (sel_data)      bus_rdata[WORD_W-1:0] = dr_word;
      else if (sel_ctrl) bus_rdata[CTRL_W-1:0] = ctrl_q;
      else if (sel_stat) bus_rdata[NFLAG-1:0]  = flags_q;
      else if (sel_en)   bus_rdata[NFLAG-1:0]  = en_q;
   end
endmodule

// File: rtl/rxs_chk.sv
module rxs_chk #(
   parameter int WORD_W = 32,
   parameter int PAR_LO = 4,
   parameter int BUS_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              word_valid,
   input logic [WORD_W-1:0] word_in,
   input logic              sync_pulse,
   input logic              ctrl_valid,
   input logic              bus_wr,
   input logic              wr_clr,
   input logic [BUS_W-1:0]  bus_wdata,
   input logic [5:0]        flags,
   input logic [5:0]        en,
   input logic              irq,
   input logic              dr_full,
   input logic              hold_full,
   input logic [WORD_W-1:0] dr_word
);
   // R2
   direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid && !dr_full && !hold_full |=> dr_full && dr_word == $past(word_in));
   // R4
   overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid && dr_full && hold_full |=> flags[3] && $stable(dr_word));
   // R5
   parity_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid && (^word_in[WORD_W-1:PAR_LO]) |=> flags[2]);
   // R6
   ctrl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_valid |=> flags[1]);
   // R9
   sync_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_pulse |=> flags[5]);
   // R8
   sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr && bus_wdata[5] && !sync_pulse |=> !flags[5]);
   // R10
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en == 6'd0 |-> !irq);
   // R1
   reset_empty_chk: assert property (@(posedge clk)
      !rst_n |=> !dr_full && !hold_full && flags == 6'd0);
endmodule

bind rx_status_ctrl rxs_chk #(.WORD_W(WORD_W), .PAR_LO(PAR_LO), .BUS_W(BUS_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_in(word_in),
   .sync_pulse(sync_pulse), .ctrl_valid(ctrl_valid), .bus_wr(bus_wr),
   .wr_clr(wr_clr), .bus_wdata(bus_wdata), .flags(flags_q), .en(en_q), .irq(irq),
   .dr_full(dr_full), .hold_full(hold_full), .dr_word(dr_word)
);

// File: tb/rx_status_ctrl_tb.sv
`timescale 1ns/1ps
module rx_status_ctrl_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic word_valid = 0, sync_pulse = 0, blk_pulse = 0, ctrl_valid = 0;
   logic bus_wr = 0, bus_rd = 0;
   logic [31:0] word_in = '0, ctrl_in = '0, bus_wdata = '0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   always #2 clk = ~clk;

   rx_status_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_in(word_in),
      .sync_pulse(sync_pulse), .blk_pulse(blk_pulse), .ctrl_valid(ctrl_valid),
      .ctrl_in(ctrl_in), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   int checks = 0, failures = 0;
   string tag = "R1";

   // behavioural reference
   bit [31:0] m_dr, m_ctrl;
   bit        m_dr_ok;
   bit [31:0] m_wait[$];
   bit [5:0]  m_flag, m_en;

   task automatic expect_eq(string req, string what, longint act, longint exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic model_step();
      bit had_dr = m_dr_ok;
      int had_wait = m_wait.size();
      bit [5:0] setv = 0, clrv = 0;
      if (!had_dr && had_wait > 0) begin m_dr = m_wait.pop_front(); m_dr_ok = 1; end
      else if (bus_rd && bus_addr == 0 && had_dr) m_dr_ok = 0;
      if (word_valid) begin
         if (!had_dr && had_wait == 0) begin m_dr = word_in; m_dr_ok = 1; end
         else if (had_wait == 0 || !had_dr) m_wait.push_back(word_in);
         else setv[3] = 1;
         if ($countones(word_in[31:4]) % 2 == 1) setv[2] = 1;
      end
      if (sync_pulse) setv[5] = 1;
      if (blk_pulse)  setv[4] = 1;
      if (bus_wr && bus_addr == 3) clrv = bus_wdata[5:0] & 6'b111100;
      m_flag[5:2] = setv[5:2] | (m_flag[5:2] & ~clrv[5:2]);
      if (ctrl_valid) begin m_flag[1] = 1; m_ctrl = ctrl_in; end
      else if (bus_rd && bus_addr == 1) m_flag[1] = 0;
      m_flag[0] = m_dr_ok;
      if (bus_wr && bus_addr == 4) m_en = bus_wdata[5:0];
   endtask

   // one clock: check read data, advance, compare irq
   task automatic cycle();
      #1;
      if (bus_rd) begin
         case (bus_addr)
            3'd0: if (m_dr_ok) expect_eq(tag, "data read", bus_rdata, m_dr);
            3'd1: expect_eq(tag, "ctrl read", bus_rdata, m_ctrl);
            3'd2: expect_eq(tag, "status read", bus_rdata, {26'd0, m_flag});
            3'd4: expect_eq(tag, "enable read", bus_rdata, {26'd0, m_en});
            default: ;
         endcase
      end
      @(posedge clk);
      model_step();
      @(negedge clk);
      expect_eq(tag, "irq", irq, |(m_flag & m_en));
      word_valid = 0; sync_pulse = 0; blk_pulse = 0; ctrl_valid = 0;
      bus_wr = 0; bus_rd = 0;
   endtask

   task automatic rd(input int a);
      bus_rd = 1; bus_addr = 3'(a); cycle();
   endtask
   task automatic wr(input int a, input bit [31:0] d);
      bus_wr = 1; bus_addr = 3'(a); bus_wdata = d; cycle();
   endtask
   task automatic send(input bit [31:0] w);
      word_valid = 1; word_in = w; cycle();
   endtask
   function automatic bit [31:0] even_word(input bit [30:0] v);
      bit [31:0] w = {1'b0, v};
      w[31] = ^w[30:4];
      return w;
   endfunction

   initial begin
      #800000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      rst_n = 1;
      // R1: state after reset
      tag = "R1";
      rd(2); rd(4);
      expect_eq("R1", "irq after reset", irq, 0);

      // R2: single word straight to data register
      tag = "R2";
      send(even_word(31'h0123_4560));
      rd(2); rd(0); rd(2);

      // R3: second word waits, data ready drops one cycle then returns
      tag = "R3";
      send(even_word(31'h1111_1110)); send(even_word(31'h2222_2220));
      rd(0); rd(2); rd(2); rd(0); rd(2);

      // R4: third word overruns and is dropped
      tag = "R4";
      send(even_word(31'h0AAA_AAA0)); send(even_word(31'h0BBB_BBB0));
      send(even_word(31'h0CCC_CCC0)); send(even_word(31'h0DDD_DDD0));
      rd(2); rd(0); cycle(); rd(0); rd(2);
      wr(3, 32'h8);

      // R5: parity covers bits 31..4 only
      tag = "R5";
      send(even_word(31'h0000_000F) ^ 32'h0000_0005); rd(2); rd(0);
      send(even_word(31'h0055_5550) ^ 32'h0000_0010); rd(2); rd(0);
      wr(3, 32'h4); rd(2);

      // R6: control word load and read-clear
      tag = "R6";
      ctrl_valid = 1; ctrl_in = 32'hC0DE_0042; cycle();
      rd(2); rd(1); rd(2);

      // R7: sync and block pulses
      tag = "R7";
      sync_pulse = 1; cycle(); blk_pulse = 1; cycle(); rd(2);

      // R8: write-one clear, zeros ignored, read-cleared bits untouched
      tag = "R8";
      send(even_word(31'h0000_1230));
      ctrl_valid = 1; ctrl_in = 32'h5; cycle();
      wr(3, 32'h0); rd(2);
      wr(3, 32'h3); rd(2);
      wr(3, 32'h10); rd(2);
      wr(3, 32'h3F); rd(2);
      rd(0); rd(1); rd(2);

      // R9: set beats clear in the same cycle
      tag = "R9";
      sync_pulse = 1; blk_pulse = 1; bus_wr = 1; bus_addr = 3; bus_wdata = 32'h30; cycle();
      rd(2); wr(3, 32'h30); rd(2);

      // R10: interrupt through enable mask
      tag = "R10";
      wr(4, 32'h3F); rd(4);
      for (int b = 0; b < 6; b++) begin
         wr(4, 32'(1 << b));
         sync_pulse = 1; cycle();
         blk_pulse = 1; cycle();
         send(even_word(31'h0000_0770) ^ 32'h10);
         send(even_word(31'h0000_0880));
         send(even_word(31'h0000_0990));
         ctrl_valid = 1; ctrl_in = 32'(b); cycle();
         rd(2);
         rd(0); cycle(); rd(0); rd(1);
         wr(3, 32'h3C); rd(2);
      end
      wr(4, 32'h0); sync_pulse = 1; cycle(); rd(2);
      wr(3, 32'h20);

      // R11: status reads have no side effect
      tag = "R11";
      send(even_word(31'h0000_4440)); ctrl_valid = 1; ctrl_in = 32'h9; cycle();
      blk_pulse = 1; cycle();
      rd(2); rd(2); rd(2);
      rd(0); rd(1); rd(2);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule